// File: doc/BRIEF.md
# Clock Stop and Power-Down Sequencer

This block is the digital control for the output banks of a multi-output clock generator. Each bank has one source clock: the CPU bank, the PCI bank, the free-running PCI bank and the 48 MHz bank. The block passes the source clock to the bank's pins through a gate. The gate enable changes only while its source is low, so a bank always stops in the low state and every high pulse it emits is a full half-period.

There are three active-low control inputs: CPU stop, PCI stop and power-down. All three are asynchronous. They are synchronized to the reference clock, which is the free-running PCI clock. A small sequencer running on that clock drives four per-bank gate requests, and the banks on other clocks resynchronize their requests.

When power-down is asserted, the sequencer first closes every gate. It then waits a parking window so that the slowest bank has settled low. Only after that does it remove the VCO enable, and one reference period later the oscillator enable. When power-down is released, the oscillator enable returns first and the VCO enable follows one period later. A wake counter stands in for oscillator and PLL settling, and the gates reopen only after it expires. The same wake counter is run after reset, which models a cold start.

Top module: `clk_stop_seq`

## Requirements
- R1: While rst_n is low at rising edges of clk_ref, every gated output is low and both osc_en and vco_en are high.
- R2: After reset is released, no gated output pulses until the wake counter of WAKE_CYCLES reference periods has expired. All four banks run within WAKE_CYCLES+10 reference periods.
- R3: With pwr_dn_n high and pci_stop_n high, driving cpu_stop_n low silences the CPU bank within 6 reference periods. The PCI, free-running PCI and 48 MHz banks keep toggling.
- R4: Returning cpu_stop_n high restarts the CPU bank within 6 reference periods.
- R5: With pwr_dn_n high, driving pci_stop_n low silences the PCI bank within 6 reference periods while the CPU, free-running PCI and 48 MHz banks keep toggling. Releasing it restarts the PCI bank within 6 reference periods.
- R6: Every high pulse on every gated output lasts one full high phase of its source clock (within 0.1 ns).
- R7: Driving pwr_dn_n low silences all four banks within 12 reference periods. vco_en falls only once every output is low. osc_en falls one reference period after vco_en.
- R8: While pwr_dn_n is low, toggling cpu_stop_n and pci_stop_n produces no pulse on any output and does not raise either enable.
- R9: Releasing pwr_dn_n raises osc_en within 5 reference periods, with vco_en rising no earlier than osc_en. The banks then resume after the wake counter, and each bank follows the stop inputs as they stand at that time.
- R10: If cpu_stop_n is released in the same cycle that pwr_dn_n is asserted, power-down wins and the CPU bank emits no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference / free-running PCI source clock; sequencer clock |
| clk_cpu | input | 1 | CPU bank source clock |
| clk_usb | input | 1 | 48 MHz bank source clock |
| rst_n | input | 1 | Synchronous active-low reset (clk_ref domain) |
| cpu_stop_n | input | 1 | Asynchronous CPU bank stop request, active low |
| pci_stop_n | input | 1 | Asynchronous PCI bank stop request, active low |
| pwr_dn_n | input | 1 | Asynchronous power-down request, active low |
| cpu_clk_o | output | NUM_CPU | Gated CPU clocks |
| pci_clk_o | output | NUM_PCI | Gated PCI clocks |
| pcif_clk_o | output | 1 | Gated free-running PCI clock (stops only in power-down) |
| usb_clk_o | output | 1 | Gated 48 MHz clock (stops only in power-down) |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | PLL/VCO enable |

## Verification
A CPU-stop release and a power-down entry can reach the sequencer on the same reference edge. The result then depends on the priority between the two paths. The bench provokes this by changing cpu_stop_n and pwr_dn_n in the same instant, after the CPU bank has been stopped. It judges the outcome by counting CPU output edges from that instant through full power-down: any edge means that the release briefly reopened the gate. A pulse-width monitor on every bank runs throughout, so any truncated pulse around that collision is also caught.

// File: rtl/clkseq_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the clock stop sequencer.
// Assumes bank indices are fixed; the sequencer and top agree on them.
package clkseq_pkg;
    localparam int BK_CPU  = 0;
    localparam int BK_PCI  = 1;
    localparam int BK_PCIF = 2;
    localparam int BK_USB  = 3;
    localparam int NBANK   = 4;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PARK = 2'd1,
        ST_OFF  = 2'd2,
        ST_WAKE = 2'd3
    } seq_state_t;
endpackage

// File: rtl/clkseq_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer, WIDTH independent bits.
// Assumes each bit is a level that stays stable for several destination cycles.
module clkseq_sync #(
    parameter int         WIDTH   = 1,
    parameter logic [0:0] RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    // Capture the asynchronous level, then re-register it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= {WIDTH{RST_VAL}};
            stab_q <= {WIDTH{RST_VAL}};
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/clkseq_fsm.sv
`timescale 1ns/1ps
// Power sequencer in the reference domain. Owns the per-bank gate requests
// and the oscillator / VCO enables; runs the park window and wake counter.
// Assumes inputs are already synchronized to clk and PARK_CYCLES covers the
// slowest bank's request crossing plus its falling-edge gate register.
module clkseq_fsm
    import clkseq_pkg::*;
#(
    parameter int PARK_CYCLES = 4,
    parameter int WAKE_CYCLES = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_run_s,
    input  logic             pci_run_s,
    input  logic             pd_s,
    output logic [NBANK-1:0] req_q,
    output logic             osc_en_q,
    output logic             vco_en_q
);
    localparam int CMAX = (WAKE_CYCLES > PARK_CYCLES) ? WAKE_CYCLES : PARK_CYCLES;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] PARK_LD = CW'(PARK_CYCLES - 1);
    localparam logic [CW-1:0] WAKE_LD = CW'(WAKE_CYCLES - 1);

    seq_state_t       state_q, state_n;
    logic [CW-1:0]    cnt_q, cnt_n;
    logic [NBANK-1:0] req_n;

    // Next-state and counter: park first on power-down, wake by counter.
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (pd_s) begin
                    state_n = ST_PARK;
                    cnt_n   = PARK_LD;
                end
            end
            ST_PARK: begin
                if (cnt_q == '0) state_n = ST_OFF;
                else             cnt_n   = cnt_q - 1'b1;
            end
            ST_OFF: begin
                if (!pd_s) begin
                    state_n = ST_WAKE;
                    cnt_n   = WAKE_LD;
                end
            end
            ST_WAKE: begin
                if (pd_s) begin
                    state_n = ST_PARK;
                    cnt_n   = PARK_LD;
                end else if (cnt_q == '0) begin
                    state_n = ST_RUN;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            default: state_n = ST_WAKE;
        endcase
    end

    // Gate requests follow the stop inputs only in the run state.
    always_comb begin
        req_n = '0;
        if (state_n == ST_RUN) begin
            req_n[BK_CPU]  = cpu_run_s;
            req_n[BK_PCI]  = pci_run_s;
            req_n[BK_PCIF] = 1'b1;
            req_n[BK_USB]  = 1'b1;
        end
    end

    // State, counter, requests and staggered enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_WAKE;
            cnt_q    <= WAKE_LD;
            req_q    <= '0;
            osc_en_q <= 1'b1;
            vco_en_q <= 1'b1;
        end else begin
            state_q  <= state_n;
            cnt_q    <= cnt_n;
            req_q    <= req_n;
            osc_en_q <= (state_n != ST_OFF) || (state_q != ST_OFF);
            vco_en_q <= (state_n != ST_OFF) && (state_q != ST_OFF);
        end
    end

    // R8
    off_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> (req_q == '0));

    // R7
    pcif_drop_by_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_q[BK_PCIF]) |-> $past(pd_s));

    // R7
    vco_off_after_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vco_en_q) |-> ($past(state_q) == ST_PARK));

    // R9
    vco_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vco_en_q |-> osc_en_q);
endmodule

// File: rtl/clkseq_gate.sv
`timescale 1ns/1ps
// Glitch-free clock gate for one bank. The enable is registered on the
// falling edge of the source, so it changes only while the source is low.
// RESYNC selects a two-flop crossing when the request comes from another domain.
module clkseq_gate #(
    parameter bit RESYNC = 1'b1
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic req,
    output logic en_o,
    output logic clk_o
);
    logic req_l;
    logic en_q;

    if (RESYNC) begin : g_xing
        clkseq_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_req_sync (
            .clk   (clk_src),
            .rst_n (rst_n),
            .d     (req),
            .q     (req_l)
        );
    end else begin : g_direct
        assign req_l = req;
    end

    // Update the enable while the source is low to keep pulses whole.
    always_ff @(negedge clk_src) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= req_l;
    end

    assign en_o  = en_q;
    assign clk_o = clk_src & en_q;
endmodule

// File: rtl/clk_stop_seq.sv
`timescale 1ns/1ps
// Top of the clock stop and power-down sequencer. Synchronizes the three
// control inputs to clk_ref, runs the sequencer, and gates four banks.
// Assumes clk_ref is the free-running PCI source and keeps running in this model.
module clk_stop_seq
    import clkseq_pkg::*;
#(
    parameter int NUM_CPU     = 2,
    parameter int NUM_PCI     = 5,
    parameter int PARK_CYCLES = 4,
    parameter int WAKE_CYCLES = 100000
) (
    input  logic               clk_ref,
    input  logic               clk_cpu,
    input  logic               clk_usb,
    input  logic               rst_n,
    input  logic               cpu_stop_n,
    input  logic               pci_stop_n,
    input  logic               pwr_dn_n,
    output logic [NUM_CPU-1:0] cpu_clk_o,
    output logic [NUM_PCI-1:0] pci_clk_o,
    output logic               pcif_clk_o,
    output logic               usb_clk_o,
    output logic               osc_en,
    output logic               vco_en
);
    logic [2:0]       ctl_s;
    logic [NBANK-1:0] req;
    logic [NBANK-1:0] bank_src;
    logic [NBANK-1:0] gate_en;
    logic [NBANK-1:0] bank_clk;

    clkseq_sync #(.WIDTH(3), .RST_VAL(1'b1)) u_ctl_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     ({pwr_dn_n, pci_stop_n, cpu_stop_n}),
        .q     (ctl_s)
    );

    clkseq_fsm #(.PARK_CYCLES(PARK_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .cpu_run_s (ctl_s[0]),
        .pci_run_s (ctl_s[1]),
        .pd_s      (~ctl_s[2]),
        .req_q     (req),
        .osc_en_q  (osc_en),
        .vco_en_q  (vco_en)
    );

    assign bank_src[BK_CPU]  = clk_cpu;
    assign bank_src[BK_PCI]  = clk_ref;
    assign bank_src[BK_PCIF] = clk_ref;
    assign bank_src[BK_USB]  = clk_usb;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        clkseq_gate #(.RESYNC((b == BK_CPU) || (b == BK_USB))) u_gate (
            .clk_src (bank_src[b]),
            .rst_n   (rst_n),
            .req     (req[b]),
            .en_o    (gate_en[b]),
            .clk_o   (bank_clk[b])
        );
    end

    assign cpu_clk_o  = {NUM_CPU{bank_clk[BK_CPU]}};
    assign pci_clk_o  = {NUM_PCI{bank_clk[BK_PCI]}};
    assign pcif_clk_o = bank_clk[BK_PCIF];
    assign usb_clk_o  = bank_clk[BK_USB];

    // R7
    parked_before_vco_off_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !vco_en |-> (gate_en == '0));
endmodule

// File: tb/clk_stop_seq_bench.sv
`timescale 1ns/1ps
module clk_stop_seq_bench;
    localparam int WAKE = 40;

    logic clk_ref = 1'b0, clk_cpu = 1'b0, clk_usb = 1'b0;
    logic rst_n = 1'b0, cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn_n = 1'b1;
    logic [1:0] cpu_clk_o;
    logic [4:0] pci_clk_o;
    logic pcif_clk_o, usb_clk_o, osc_en, vco_en;

    int n_chk = 0, n_fail = 0;
    int e_cpu = 0, e_pci = 0, e_pcif = 0, e_usb = 0;
    int bad_w = 0, n_pulse = 0;
    int vco_fall = 0, vco_fall_bad = 0, vco_rise = 0, vco_rise_bad = 0;
    realtime r_cpu, r_pci, r_pcif, r_usb;

    always #2.5 clk_cpu = ~clk_cpu;
    always #7.5 clk_ref = ~clk_ref;
    initial begin
        #1.3;
        forever #5 clk_usb = ~clk_usb;
    end

    clk_stop_seq #(.NUM_CPU(2), .NUM_PCI(5), .PARK_CYCLES(4), .WAKE_CYCLES(WAKE)) u_clk_stop_seq (
        .clk_ref(clk_ref), .clk_cpu(clk_cpu), .clk_usb(clk_usb), .rst_n(rst_n),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n),
        .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o), .pcif_clk_o(pcif_clk_o),
        .usb_clk_o(usb_clk_o), .osc_en(osc_en), .vco_en(vco_en));

    // Edge counters and R6 pulse-width monitors.
    always @(posedge cpu_clk_o[0]) begin e_cpu++; r_cpu = $realtime; end
    always @(posedge pci_clk_o[0]) begin e_pci++; r_pci = $realtime; end
    always @(posedge pcif_clk_o) begin e_pcif++; r_pcif = $realtime; end
    always @(posedge usb_clk_o) begin e_usb++; r_usb = $realtime; end
    task automatic width(realtime t0, realtime half);
        realtime w = $realtime - t0;
        n_pulse++;
        if (w < half - 0.1 || w > half + 0.1) bad_w++;
    endtask
    always @(negedge cpu_clk_o[0]) width(r_cpu, 2.5);
    always @(negedge pci_clk_o[0]) width(r_pci, 7.5);
    always @(negedge pcif_clk_o) width(r_pcif, 7.5);
    always @(negedge usb_clk_o) width(r_usb, 5.0);

    // R7 / R9 enable ordering monitors.
    always @(negedge vco_en) if (rst_n) begin
        vco_fall++;
        if (cpu_clk_o != 0 || pci_clk_o != 0 || pcif_clk_o || usb_clk_o || !osc_en) vco_fall_bad++;
    end
    always @(posedge vco_en) if (rst_n) begin
        vco_rise++;
        if (!osc_en) vco_rise_bad++;
    end

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_ref(int n);
        repeat (n) @(posedge clk_ref);
        #2;
    endtask

    task automatic window(int n, output int dc, output int dp, output int df, output int du);
        int c0 = e_cpu, p0 = e_pci, f0 = e_pcif, u0 = e_usb;
        wait_ref(n);
        dc = e_cpu - c0; dp = e_pci - p0; df = e_pcif - f0; du = e_usb - u0;
    endtask

    task automatic t_reset;
        wait_ref(6);
        chk(cpu_clk_o == 0 && pci_clk_o == 0 && !pcif_clk_o && !usb_clk_o, "R1", "outputs low in reset",
            int'({cpu_clk_o, pci_clk_o, pcif_clk_o, usb_clk_o}), 0);
        chk(osc_en && vco_en, "R1", "enables high in reset", int'({osc_en, vco_en}), 3);
    endtask

    task automatic t_cold_start;
        int dc, dp, df, du;
        rst_n = 1'b1;
        window(WAKE - 2, dc, dp, df, du);
        chk(dc + dp + df + du == 0, "R2", "silent during wake count", dc + dp + df + du, 0);
        wait_ref(12);
        window(8, dc, dp, df, du);
        chk(dc > 0 && dp > 0 && df > 0 && du > 0, "R2", "all banks running after wake",
            (dc > 0) + (dp > 0) + (df > 0) + (du > 0), 4);
    endtask

    task automatic t_cpu_stop;
        int dc, dp, df, du;
        cpu_stop_n = 1'b0;
        wait_ref(6);
        window(10, dc, dp, df, du);
        chk(dc == 0 && cpu_clk_o == 0, "R3", "cpu bank silent", dc, 0);
        chk(dp > 0 && df > 0 && du > 0, "R3", "other banks run", (dp > 0) + (df > 0) + (du > 0), 3);
        cpu_stop_n = 1'b1;
        wait_ref(6);
        window(6, dc, dp, df, du);
        chk(dc > 0, "R4", "cpu bank restarted", dc, 1);
    endtask

    task automatic t_pci_stop;
        int dc, dp, df, du;
        pci_stop_n = 1'b0;
        wait_ref(6);
        window(10, dc, dp, df, du);
        chk(dp == 0 && pci_clk_o == 0, "R5", "pci bank silent", dp, 0);
        chk(dc > 0 && df > 0 && du > 0, "R5", "other banks run", (dc > 0) + (df > 0) + (du > 0), 3);
        pci_stop_n = 1'b1;
        wait_ref(6);
        window(6, dc, dp, df, du);
        chk(dp > 0, "R5", "pci bank restarted", dp, 1);
    endtask

    task automatic t_power_down;
        int dc, dp, df, du;
        pwr_dn_n = 1'b0;
        wait_ref(12);
        window(6, dc, dp, df, du);
        chk(dc + dp + df + du == 0, "R7", "all banks silent", dc + dp + df + du, 0);
        chk(!vco_en && !osc_en, "R7", "enables dropped", int'({osc_en, vco_en}), 0);
        chk(vco_fall == 1 && vco_fall_bad == 0, "R7", "vco fell once, parked, osc still on",
            vco_fall_bad, 0);
        cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
        window(5, dc, dp, df, du);
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        window(5, dc, dp, df, du);
        cpu_stop_n = 1'b0;
        window(5, dc, dp, df, du);
        chk(dc + dp + df + du == 0, "R8", "stop toggles ignored", dc + dp + df + du, 0);
        chk(!vco_en && !osc_en, "R8", "enables stay low", int'({osc_en, vco_en}), 0);
    endtask

    task automatic t_wake;
        int dc, dp, df, du;
        pwr_dn_n = 1'b1;
        wait_ref(5);
        chk(osc_en && vco_en, "R9", "enables back", int'({osc_en, vco_en}), 3);
        chk(vco_rise == 1 && vco_rise_bad == 0, "R9", "osc before vco", vco_rise_bad, 0);
        wait_ref(WAKE + 8);
        window(8, dc, dp, df, du);
        chk(dc == 0, "R9", "cpu bank honours stop after wake", dc, 0);
        chk(dp > 0 && df > 0 && du > 0, "R9", "other banks resume", (dp > 0) + (df > 0) + (du > 0), 3);
    endtask

    task automatic t_same_edge;
        int dc, dp, df, du;
        cpu_stop_n = 1'b1;
        pwr_dn_n = 1'b0;
        window(16, dc, dp, df, du);
        chk(dc == 0, "R10", "no cpu pulse when release meets power-down", dc, 0);
        chk(!vco_en, "R10", "power-down reached", int'(vco_en), 0);
        pwr_dn_n = 1'b1;
        wait_ref(WAKE + 12);
        window(8, dc, dp, df, du);
        chk(dc > 0 && dp > 0 && df > 0 && du > 0, "R10", "all banks run after wake",
            (dc > 0) + (dp > 0) + (df > 0) + (du > 0), 4);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        t_reset();
        t_cold_start();
        t_cpu_stop();
        t_pci_stop();
        cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
        begin
            int dc, dp, df, du;
            wait_ref(6);
            window(8, dc, dp, df, du);
            chk(dc == 0 && dp == 0 && df > 0 && du > 0, "R3", "both stops: only fixed banks run",
                (dc > 0) + (dp > 0) + (df > 0) + (du > 0), 2);
        end
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        wait_ref(8);
        t_power_down();
        t_wake();
        t_same_edge();
        chk(bad_w == 0 && n_pulse > 0, "R6", "all high pulses full width", bad_w, 0);
        report();
    end
endmodule